// File: doc/BRIEF.md
# MII PHY Scan and Duplex Resolver

This block is a management-bus master that, on a start pulse, searches the management addresses for attached transceivers, records the advertisement word of each one it finds, and then reads the link-partner ability word of the first transceiver found. It combines that word with the stored advertisement and resolves full or half duplex. It drives the management clock and data lines itself, releases the data line for the read part of every frame, and paces the clock from a divider derived from its parameters.

The top controller steps through seven named states. `T_IDLE` waits for `start` (start → `T_PROBE`). `T_PROBE` issues a status-register read at the current address (→ `T_PROBE_WAIT`). `T_PROBE_WAIT` waits for the read to finish. It then goes to `T_ADV` if the transceiver responded. If none responded at address 31, it goes to `T_LPA` when at least one was found and to `T_IDLE` when none was. Otherwise it moves to the next address and returns to `T_PROBE`. `T_ADV` issues an advertisement read (→ `T_ADV_WAIT`). `T_ADV_WAIT` stores the word. It then goes to `T_LPA` when the count has reached its limit or the address is 31, and back to `T_PROBE` otherwise. `T_LPA` issues the partner-ability read to the first transceiver found (→ `T_LPA_WAIT`), and `T_LPA_WAIT` resolves the duplex and returns to `T_IDLE`.

The serial engine under the controller has its own states. `E_IDLE` waits for a request (go → `E_LOW`). `E_LOW` holds the clock low for one half period (→ `E_HIGH`). `E_HIGH` holds it high for one half period and then moves to `E_LOW` for the next bit, or to `E_IDLE` after the 68th bit.

Top module: `mii_duplex_probe`

## Requirements
- R1: After reset, `mdc`, `mdio_oe`, `busy`, `phy_count`, `full_duplex`, `duplex_changed` and `no_phy` are all 0.
- R2: Each low and each high phase of `mdc` lasts exactly HALF = ceil(CLK_HZ / (2·MDC_MAX_HZ)) clock cycles, so `mdc` never runs faster than MDC_MAX_HZ.
- R3: Every read frame drives 48 bits on `mdio_o` with `mdio_oe`=1, each changing while `mdc` is low and held through the rising edge. These are 32 ones, then the pattern 110110, then the 5-bit transceiver address and the 5-bit register number, both most significant bit first.
- R4: After the 48th bit `mdio_oe` drops and 20 samples of `mdio_i` are taken on the `mdc` rising edges. Numbering the samples 19 down to 0 in arrival order, the read word is samples 16..1.
- R5: The scan reads register 1 at addresses 1, 2, … 31 in ascending order and stops issuing reads of register 1 once `MAX_PHYS` (4) transceivers have been found. `phy_count` ends at the number found, and `phy_first` at the lowest responding address.
- R6: A transceiver responds when its register-1 word is neither 16'hFFFF nor 16'h0000.
- R7: Each responding transceiver gets a read of register 4 right after its register-1 read. `adv_word` ends holding the register-4 word of the last transceiver found, and is 0 when none is found.
- R8: When no transceiver responds, `no_phy` is set, `phy_count` is 0, no register-5 read is made, and `full_duplex` keeps its value.
- R9: Otherwise register 5 of `phy_first` is read and ANDed with `adv_word`. Full duplex is chosen when bit 8 of the result is 1 or when bits 8:6 are 3'b001. Any other value gives half duplex.
- R10: When `dup_lock` is 1, or the register-5 word is 16'hFFFF, `full_duplex` is left as it was and `duplex_changed` stays 0.
- R11: `duplex_changed` is a single-cycle pulse. It fires in the cycle `full_duplex` takes a new value, and only then.
- R12: A `start` pulse while `busy` is 1 is ignored: the running scan issues the same reads and ends with the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run a scan |
| dup_lock | input | 1 | Holds the current duplex setting |
| mdio_i | input | 1 | Management data line as received |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven out |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| busy | output | 1 | A scan is in progress |
| phy_first | output | 5 | Lowest address that responded |
| phy_count | output | 3 | Number of transceivers found (at most 4) |
| adv_word | output | 16 | Stored advertisement word |
| full_duplex | output | 1 | 1 = full duplex, 0 = half duplex |
| duplex_changed | output | 1 | Pulse when `full_duplex` changes |
| no_phy | output | 1 | No transceiver responded in the last scan |

## Verification
A wrong bit counter in the engine shows within one frame as a header that is not 48 bits long or a read word shifted by one position. That in turn changes `adv_word` or the presence decision at the end of the scan. A controller that moves to the wrong address or misses the stop at four issues a different read sequence, and the transceiver model logs that sequence read by read. A wrong resolve or lock path shows only at the end of the scan, in `full_duplex` and in the count of `duplex_changed` pulses, so every scenario compares these against a model that carries the duplex state over from one scenario to the next.

// File: rtl/mdio_probe_pkg.sv
package mdio_probe_pkg;
    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 16;
    localparam int RD_BITS    = 20;
    localparam int FRAME_BITS = PRE_BITS + HDR_BITS + RD_BITS;
    localparam int RD_START   = PRE_BITS + HDR_BITS;
    // start 01 / read 10, preceded by two ones
    localparam logic [5:0] HDR_PREFIX = 6'b110110;
    localparam logic [4:0] REG_STATUS  = 5'd1;
    localparam logic [4:0] REG_ADVERT  = 5'd4;
    localparam logic [4:0] REG_PARTNER = 5'd5;
    localparam logic [4:0] LAST_ADDR   = 5'd31;

    typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH} eng_state_t;
    typedef enum logic [2:0] {
        T_IDLE, T_PROBE, T_PROBE_WAIT, T_ADV, T_ADV_WAIT, T_LPA, T_LPA_WAIT
    } ctl_state_t;
endpackage

// File: rtl/mdio_rd_engine.sv
module mdio_rd_engine
    import mdio_probe_pkg::*;
#(
    parameter int HALF = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic [15:0] rdata
);
    localparam int DIV_W = $clog2(HALF + 1);
    localparam int BIT_W = $clog2(FRAME_BITS + 1);
    // samples 19..0 arrive in order; keep samples 16..1
    localparam int KEEP_LO = RD_START + 3;
    localparam int KEEP_HI = FRAME_BITS - 2;

    eng_state_t st_q, st_d;
    logic [DIV_W-1:0]    div_q;
    logic [BIT_W-1:0]    bit_q;
    logic [HDR_BITS-1:0] hdr_q;
    logic [15:0]         rx_q;
    logic                tick, last_bit;

    assign tick     = (div_q == DIV_W'(HALF - 1));
    assign last_bit = (bit_q == BIT_W'(FRAME_BITS - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            E_IDLE:  if (go)   st_d = E_LOW;
            E_LOW:   if (tick) st_d = E_HIGH;
            E_HIGH:  if (tick) st_d = last_bit ? E_IDLE : E_LOW;
            default: st_d = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= E_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            bit_q <= '0;
            hdr_q <= '0;
            rx_q  <= '0;
            mdc   <= 1'b0;
            done  <= 1'b0;
        end else begin
            done  <= 1'b0;
            mdc   <= (st_d == E_HIGH);
            div_q <= (st_q == E_IDLE || tick) ? '0 : div_q + 1'b1;
            if (st_q == E_IDLE && go) begin
                bit_q <= '0;
                hdr_q <= {HDR_PREFIX, phy_addr, reg_addr};
            end
            // sample on the rising edge of mdc
            if (st_q == E_LOW && tick && bit_q >= BIT_W'(KEEP_LO)
                && bit_q <= BIT_W'(KEEP_HI))
                rx_q <= {rx_q[14:0], mdio_i};
            if (st_q == E_HIGH && tick) begin
                bit_q <= bit_q + 1'b1;
                if (bit_q >= BIT_W'(PRE_BITS))
                    hdr_q <= {hdr_q[HDR_BITS-2:0], 1'b0};
                if (last_bit) done <= 1'b1;
            end
        end
    end

    assign mdio_oe = (st_q != E_IDLE) && (bit_q < BIT_W'(RD_START));
    assign mdio_o  = mdio_oe && ((bit_q < BIT_W'(PRE_BITS)) || hdr_q[HDR_BITS-1]);
    assign rdata   = rx_q;

    // R2: the clock only moves after a full half period
    p_mdc_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdc) |-> $past(div_q) == DIV_W'(HALF - 1));
    // R4: the data line is released only while the clock is low
    p_release_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> !mdc);
endmodule

// File: rtl/mii_duplex_probe.sv
module mii_duplex_probe
    import mdio_probe_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int MDC_MAX_HZ = 2_500_000,
    parameter int MAX_PHYS   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        dup_lock,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        busy,
    output logic [4:0]  phy_first,
    output logic [2:0]  phy_count,
    output logic [15:0] adv_word,
    output logic        full_duplex,
    output logic        duplex_changed,
    output logic        no_phy
);
    localparam int HALF = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);

    ctl_state_t st_q, st_d;
    logic [4:0]  addr_q;
    logic        eng_go, eng_done;
    logic [4:0]  eng_phy, eng_reg;
    logic [15:0] eng_data, negotiated;
    logic        present, last_addr, full_cap, resolved;

    assign present    = (eng_data != 16'hFFFF) && (eng_data != 16'h0000);
    assign last_addr  = (addr_q == LAST_ADDR);
    assign full_cap   = (phy_count == 3'(MAX_PHYS));
    assign negotiated = eng_data & adv_word;
    assign resolved   = negotiated[8] || (negotiated[8:6] == 3'b001);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            T_IDLE:       if (start) st_d = T_PROBE;
            T_PROBE:      st_d = T_PROBE_WAIT;
            T_PROBE_WAIT: if (eng_done) begin
                if (present)                  st_d = T_ADV;
                else if (!last_addr)          st_d = T_PROBE;
                else if (phy_count != 3'd0)   st_d = T_LPA;
                else                          st_d = T_IDLE;
            end
            T_ADV:        st_d = T_ADV_WAIT;
            T_ADV_WAIT:   if (eng_done) st_d = (full_cap || last_addr) ? T_LPA : T_PROBE;
            T_LPA:        st_d = T_LPA_WAIT;
            T_LPA_WAIT:   if (eng_done) st_d = T_IDLE;
            default:      st_d = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= T_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q         <= 5'd1;
            phy_first      <= '0;
            phy_count      <= '0;
            adv_word       <= '0;
            full_duplex    <= 1'b0;
            duplex_changed <= 1'b0;
            no_phy         <= 1'b0;
        end else begin
            duplex_changed <= 1'b0;
            unique case (st_q)
                T_IDLE: if (start) begin
                    addr_q    <= 5'd1;
                    phy_first <= '0;
                    phy_count <= '0;
                    adv_word  <= '0;
                    no_phy    <= 1'b0;
                end
                T_PROBE_WAIT: if (eng_done) begin
                    if (present) begin
                        phy_count <= phy_count + 1'b1;
                        if (phy_count == 3'd0) phy_first <= addr_q;
                    end else if (!last_addr) begin
                        addr_q <= addr_q + 1'b1;
                    end else if (phy_count == 3'd0) begin
                        no_phy <= 1'b1;
                    end
                end
                T_ADV_WAIT: if (eng_done) begin
                    adv_word <= eng_data;
                    if (!full_cap && !last_addr) addr_q <= addr_q + 1'b1;
                end
                T_LPA_WAIT: if (eng_done && !dup_lock && eng_data != 16'hFFFF
                                && resolved != full_duplex) begin
                    full_duplex    <= resolved;
                    duplex_changed <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy    = (st_q != T_IDLE);
    assign eng_go  = (st_q == T_PROBE) || (st_q == T_ADV) || (st_q == T_LPA);
    assign eng_phy = (st_q == T_LPA) ? phy_first : addr_q;
    assign eng_reg = (st_q == T_LPA) ? REG_PARTNER :
                     (st_q == T_ADV) ? REG_ADVERT : REG_STATUS;

    mdio_rd_engine #(.HALF(HALF)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (eng_go),
        .phy_addr (eng_phy),
        .reg_addr (eng_reg),
        .mdio_i   (mdio_i),
        .mdc      (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (eng_done),
        .rdata    (eng_data)
    );

    p_oe_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);
    p_count_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phy_count <= 3'(MAX_PHYS));
    p_first_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_count != 3'd0) |-> (phy_first != 5'd0));
    p_nophy_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        no_phy |-> (phy_count == 3'd0));
    p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dup_lock) |-> $stable(full_duplex));
    p_chg_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        duplex_changed |=> !duplex_changed);
    p_chg_flip_r11: assert property (@(posedge clk) disable iff (!rst_n)
        duplex_changed |-> (full_duplex != $past(full_duplex)));
    p_quiet_flip_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !duplex_changed |-> $stable(full_duplex));
endmodule

// File: tb/tb_mii_duplex_probe.sv
module tb_mii_duplex_probe;
    localparam int HALF_TB = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic dup_lock = 1'b0;
    logic mdio_i = 1'b1;
    logic mdc, mdio_o, mdio_oe, busy, full_duplex, duplex_changed, no_phy;
    logic [4:0]  phy_first;
    logic [2:0]  phy_count;
    logic [15:0] adv_word;

    always #5 clk = ~clk;

    mii_duplex_probe #(.CLK_HZ(100_000_000), .MDC_MAX_HZ(25_000_000), .MAX_PHYS(4)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dup_lock(dup_lock), .mdio_i(mdio_i),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy),
        .phy_first(phy_first), .phy_count(phy_count), .adv_word(adv_word),
        .full_duplex(full_duplex), .duplex_changed(duplex_changed), .no_phy(no_phy)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    // transceiver register model
    logic [15:0] r1 [32];
    logic [15:0] r4 [32];
    logic [15:0] r5 [32];

    // observed read log
    logic [4:0] lp [64];
    logic [4:0] lr [64];
    int nread = 0, frame_err = 0, nchg = 0, min_phase = 1000, phase_len = 0;
    logic [47:0] sh = '0;
    int nout = 0, rx_idx = 0;
    logic [19:0] wv = '1;
    logic prev_mdc = 1'b0, prev_oe = 1'b0;

    // expected model
    logic [4:0] ep [64];
    logic [4:0] er [64];
    int en, ecount, efirst;
    logic [15:0] eadv;
    bit enophy, echg, edup = 0;

    function automatic logic [15:0] reg_val(input logic [4:0] p, input logic [4:0] r);
        if (r == 5'd1) return r1[p];
        if (r == 5'd4) return r4[p];
        if (r == 5'd5) return r5[p];
        return 16'h0000;
    endfunction

    function automatic bit resolve_full(input logic [15:0] lpa, input logic [15:0] adv);
        logic [15:0] n;
        n = lpa & adv;
        return n[8] || (n[8:6] == 3'b001);
    endfunction

    always @(negedge clk) begin
        if (mdc != prev_mdc) begin
            if (busy && phase_len < min_phase) min_phase = phase_len;
            phase_len = 1;
        end else begin
            phase_len++;
        end
        if (duplex_changed) nchg++;
        if (prev_oe && !mdio_oe) begin
            // header complete: 32 ones, prefix, address, register
            if (nout != 48 || sh[47:16] != 32'hFFFF_FFFF || sh[15:10] != 6'b110110)
                frame_err++;
            if (nread < 64) begin
                lp[nread] = sh[9:5];
                lr[nread] = sh[4:0];
            end
            nread++;
            wv = {3'b101, reg_val(sh[9:5], sh[4:0]), 1'b1};
            rx_idx = 0;
            nout = 0;
        end
        if (mdc && !prev_mdc) begin
            if (mdio_oe) begin
                sh = {sh[46:0], mdio_o};
                nout++;
            end else if (busy) begin
                rx_idx++;
            end
        end
        mdio_i = (!mdio_oe && busy && rx_idx < 20) ? wv[19 - rx_idx] : 1'b1;
        prev_mdc = mdc;
        prev_oe  = mdio_oe;
    end

    task automatic check(input bit ok, input string req, input string what, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d (0x%0h) expected %0d (0x%0h)", req, what, got, got, exp, exp);
        end
    endtask

    task automatic push_exp(input int p, input int r);
        ep[en] = 5'(p);
        er[en] = 5'(r);
        en++;
    endtask

    task automatic model_scan(input bit lock);
        logic [15:0] v;
        bit d;
        en = 0; ecount = 0; efirst = 0; eadv = 16'h0; enophy = 0; echg = 0;
        for (int a = 1; a < 32; a++) begin
            if (ecount == 4) break;
            push_exp(a, 1);
            if (r1[a] != 16'hFFFF && r1[a] != 16'h0000) begin
                if (ecount == 0) efirst = a;
                ecount++;
                push_exp(a, 4);
                eadv = r4[a];
            end
        end
        if (ecount == 0) begin
            enophy = 1;
        end else begin
            push_exp(efirst, 5);
            v = r5[efirst];
            if (!lock && v != 16'hFFFF) begin
                d = resolve_full(v, eadv);
                if (d != edup) begin
                    echg = 1;
                    edup = d;
                end
            end
        end
    endtask

    task automatic clear_regs();
        for (int a = 0; a < 32; a++) begin
            r1[a] = (a % 2 == 0) ? 16'hFFFF : 16'h0000;
            r4[a] = 16'h0000;
            r5[a] = 16'h0000;
        end
    endtask

    task automatic run(input bit lock, input bit mid_start, input string tag);
        bit log_ok;
        model_scan(lock);
        dup_lock = lock;
        nread = 0; nchg = 0; frame_err = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (mid_start) begin
            repeat (400) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        log_ok = (nread == en);
        for (int i = 0; i < en && i < 64; i++)
            if (lp[i] != ep[i] || lr[i] != er[i]) log_ok = 0;
        check(log_ok, mid_start ? "R12" : "R5", {tag, " read sequence (count)"}, nread, en);
        check(frame_err == 0, "R3", {tag, " frame header"}, frame_err, 0);
        check(phy_count == 3'(ecount), "R5", {tag, " phy_count"}, phy_count, ecount);
        check(phy_first == 5'(efirst), "R5", {tag, " phy_first"}, phy_first, efirst);
        check(adv_word == eadv, "R7", {tag, " adv_word (R4 sampling)"}, adv_word, eadv);
        check(no_phy == enophy, "R8", {tag, " no_phy"}, no_phy, enophy);
        check(full_duplex == edup, lock ? "R10" : "R9", {tag, " full_duplex"}, full_duplex, edup);
        check(nchg == int'(echg), "R11", {tag, " changed pulses"}, nchg, echg);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        clear_regs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(mdc == 0 && mdio_oe == 0 && busy == 0, "R1", "idle bus", {mdc, mdio_oe, busy}, 0);
        check(phy_count == 0 && no_phy == 0, "R1", "count/no_phy", {phy_count, no_phy}, 0);
        check(full_duplex == 0 && duplex_changed == 0, "R1", "duplex", {full_duplex, duplex_changed}, 0);

        // R6/R8: nothing responds (both 0xFFFF and 0x0000 present)
        clear_regs();
        run(0, 0, "none");

        // R5/R7/R9: six responders, stop after four; bit 8 gives full duplex
        clear_regs();
        r1[3] = 16'h7809; r1[7] = 16'h0001; r1[9] = 16'hFFFE; r1[12] = 16'h8000;
        r1[20] = 16'h7809; r1[25] = 16'h7809;
        r4[3] = 16'h0021; r4[7] = 16'h0041; r4[9] = 16'h00A1; r4[12] = 16'h01E1;
        r4[20] = 16'h1111; r4[25] = 16'h2222;
        r5[3] = 16'h0100;
        run(0, 0, "four");
        // R2: every mdc phase equals HALF
        check(min_phase == HALF_TB, "R2", "shortest mdc phase", min_phase, HALF_TB);

        // R12: second start during the scan has no effect
        run(0, 1, "restart");

        // address 31 only; negotiated 000 -> half
        clear_regs();
        r1[31] = 16'h796D; r4[31] = 16'h01E1; r5[31] = 16'h0020;
        run(0, 0, "last-half");
        // bits 8:6 == 001 -> full
        r4[31] = 16'h0040; r5[31] = 16'h0040;
        run(0, 0, "b001-full");
        // bits 8:6 == 011 -> half
        r4[31] = 16'h00C0; r5[31] = 16'h00C0;
        run(0, 0, "b011-half");
        // R10: lock holds although partner resolves full
        r4[31] = 16'h0100; r5[31] = 16'h0100;
        run(1, 0, "locked");
        // R10: partner word all ones is ignored
        r5[31] = 16'hFFFF;
        run(0, 0, "lpa-ffff");

        // random populations
        for (int k = 0; k < 5; k++) begin
            for (int a = 0; a < 32; a++) begin
                logic [15:0] v;
                v = 16'($urandom);
                if ($urandom_range(99) < 25) begin
                    if (v == 16'hFFFF || v == 16'h0000) v = 16'h7949;
                    r1[a] = v;
                end else begin
                    r1[a] = $urandom_range(1) ? 16'hFFFF : 16'h0000;
                end
                r4[a] = 16'($urandom);
                r5[a] = ($urandom_range(9) == 0) ? 16'hFFFF : 16'($urandom);
            end
            run($urandom_range(4) == 0, 0, $sformatf("rand%0d", k));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule